// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry Flag

This block shifts or rotates a data word by an amount taken from a register. It supports four operations: logical left, logical right, arithmetic right and rotate right. Along with the shifted word it returns the next value of the carry flag and a strobe that says whether the operation changed that flag. The shift amount covers its whole 8-bit range. Amounts equal to or greater than the word width still give well-defined results and carries. An amount of zero passes the operand through and leaves the incoming carry alone.

Operations enter on a valid/ready input handshake. Results leave on a valid/ready output handshake. With the default `REG_OUT = 1`, one output register sits between the combinational shift core and the output port. An operation accepted on one edge appears at the output after that edge. The output stays there until the consumer takes it. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so the block can take one operation per cycle without stalls. If `out_ready` is held low, the block holds its result and refuses new input. With `REG_OUT = 0` the core connects straight through: `in_ready` follows `out_ready`, and `out_valid` follows `in_valid`.

Top module: `shift_carry_unit`

## Requirements
- R1: The opcode selects the operation: 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right, 2'b11 rotate right. The whole 8-bit `amount` is significant for the first three operations.
- R2: When `amount` is 0, `result` equals the operand, `carry_out` equals `carry_in` and `carry_upd` is 0, for all four opcodes.
- R3: Logical left by n: for 1 ≤ n ≤ 31 the carry is operand bit [32−n]. For n = 32 the result is 0 and the carry is operand bit 0. For n > 32 both the result and the carry are 0.
- R4: Logical right by n: for 1 ≤ n ≤ 31 the carry is operand bit [n−1]. For n = 32 the result is 0 and the carry is operand bit 31. For n > 32 both the result and the carry are 0.
- R5: Arithmetic right by n: for 1 ≤ n ≤ 31 the result is sign-filled and the carry is operand bit [n−1]. For n ≥ 32 every result bit and the carry equal operand bit 31.
- R6: Rotate right uses only `amount[4:0]`. If those bits are zero and `amount` is nonzero, the result is the operand and the carry is operand bit 31.
- R7: Rotate right with a nonzero `amount[4:0]` = r gives the operand rotated right by r, with carry equal to operand bit [r−1].
- R8: `carry_upd` is 1 exactly when `amount` is nonzero.
- R9: An operation transfers when `in_valid` and `in_ready` are both high. Its result is presented with `out_valid` one clock later. While `out_valid` is high and `out_ready` is low, the outputs hold and `in_ready` is low.
- R10: During reset and after it, `out_valid` is 0 and `in_ready` is 1 until the first transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Block can accept an operation |
| operand | input | 32 | Word to shift |
| amount | input | 8 | Shift amount from a register |
| opcode | input | 2 | Operation select (R1 encoding) |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 32 | Shifted word |
| carry_out | output | 1 | Next carry flag |
| carry_upd | output | 1 | Carry flag was changed by this operation |

## Verification
The hardest cases to reach are at the edges of the amount range. These are amounts of exactly 32, amounts just above it, and nonzero multiples of 32 for rotate. Random amounts across 0–255 hit these values rarely. The stimulus therefore sweeps every amount from 0 to 255 for each opcode. It uses operands that isolate bit 0 and bit 31, so that a carry taken from the wrong bit shows up. Random mixes that favour amounts below 40 come after the sweep. A separate sequence holds `out_ready` low while a second operation waits at the input, to exercise the stall path.

// File: rtl/shc_pkg.sv
package shc_pkg;
  typedef enum logic [1:0] {
    SHC_LSL = 2'b00,
    SHC_LSR = 2'b01,
    SHC_ASR = 2'b10,
    SHC_ROR = 2'b11
  } shc_op_e;
endpackage

// File: rtl/shc_linear.sv
// Logical left, logical right and arithmetic right with carry; DATA_W must be a power of two.
module shc_linear
  import shc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] operand,
  input  logic [AMT_W-1:0]  amount,
  input  shc_op_e           opcode,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              carry_out
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [CNT_W-1:0]       amt_lo;
  logic [AMT_W-CNT_W-1:0] amt_hi;
  logic [CNT_W-1:0]       up_idx;
  logic [CNT_W-1:0]       dn_idx;
  logic                   in_range;
  logic                   at_width;
  logic                   sign_bit;

  assign amt_lo   = amount[CNT_W-1:0];
  assign amt_hi   = amount[AMT_W-1:CNT_W];
  assign in_range = (amt_hi == '0);
  assign at_width = (amt_hi == {{(AMT_W-CNT_W-1){1'b0}}, 1'b1}) && (amt_lo == '0);
  // width minus amount, modulo width
  assign up_idx   = (~amt_lo) + {{(CNT_W-1){1'b0}}, 1'b1};
  assign dn_idx   = amt_lo - {{(CNT_W-1){1'b0}}, 1'b1};
  assign sign_bit = operand[DATA_W-1];

  always_comb begin
    result    = operand;
    carry_out = carry_in;
    if (amount != '0) begin
      unique case (opcode)
        SHC_LSL: begin
          if (in_range) begin
            result    = operand << amt_lo;
            carry_out = operand[up_idx];
          end else begin
            result    = '0;
            carry_out = at_width ? operand[0] : 1'b0;
          end
        end
        SHC_LSR: begin
          if (in_range) begin
            result    = operand >> amt_lo;
            carry_out = operand[dn_idx];
          end else begin
            result    = '0;
            carry_out = at_width ? sign_bit : 1'b0;
          end
        end
        SHC_ASR: begin
          if (in_range) begin
            result    = $unsigned($signed(operand) >>> amt_lo);
            carry_out = operand[dn_idx];
          end else begin
            result    = {DATA_W{sign_bit}};
            carry_out = sign_bit;
          end
        end
        default: begin
          result    = operand;
          carry_out = carry_in;
        end
      endcase
    end
  end
endmodule

// File: rtl/shc_rotate.sv
// Rotate right by the amount modulo the word width.
module shc_rotate #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] operand,
  input  logic [AMT_W-1:0]  amount,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              carry_out
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [CNT_W-1:0] rot;
  logic [CNT_W-1:0] back;
  logic [CNT_W-1:0] dn_idx;

  assign rot    = amount[CNT_W-1:0];
  assign back   = (~rot) + {{(CNT_W-1){1'b0}}, 1'b1};
  assign dn_idx = rot - {{(CNT_W-1){1'b0}}, 1'b1};

  always_comb begin
    if (amount == '0) begin
      result    = operand;
      carry_out = carry_in;
    end else if (rot == '0) begin
      result    = operand;
      carry_out = operand[DATA_W-1];
    end else begin
      result    = (operand >> rot) | (operand << back);
      carry_out = operand[dn_idx];
    end
  end
endmodule

// File: rtl/shc_out_stage.sv
// Optional valid/ready output register.
module shc_out_stage #(
  parameter int PAY_W   = 34,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PAY_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PAY_W-1:0] out_data
);
  generate
    if (REG_OUT) begin : g_reg
      logic             full_q;
      logic [PAY_W-1:0] data_q;

      assign in_ready  = !full_q || out_ready;
      assign out_valid = full_q;
      assign out_data  = data_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          full_q <= 1'b0;
          data_q <= '0;
        end else begin
          if (in_ready) full_q <= in_valid;
          if (in_valid && in_ready) data_q <= in_data;
        end
      end

      // R9
      hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
      // R9
      stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !in_ready |=> out_valid);
    end else begin : g_pass
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign in_ready   = out_ready;
      assign out_valid  = in_valid;
      assign out_data   = in_data;
    end
  endgenerate
endmodule

// File: rtl/shift_carry_unit.sv
module shift_carry_unit
  import shc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int AMT_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] operand,
  input  logic [AMT_W-1:0]  amount,
  input  logic [1:0]        opcode,
  input  logic              carry_in,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] result,
  output logic              carry_out,
  output logic              carry_upd
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam int PAY_W = DATA_W + 2;
  localparam logic [AMT_W-1:0] WIDTH_AMT = AMT_W'(DATA_W);

  shc_op_e          op;
  logic [DATA_W-1:0] lin_res, rot_res, core_res;
  logic              lin_c, rot_c, core_c, core_upd;
  logic [PAY_W-1:0]  core_pay, out_pay;

  assign op = shc_op_e'(opcode);

  shc_linear #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_linear (
    .operand(operand), .amount(amount), .opcode(op), .carry_in(carry_in),
    .result(lin_res), .carry_out(lin_c)
  );

  shc_rotate #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_rotate (
    .operand(operand), .amount(amount), .carry_in(carry_in),
    .result(rot_res), .carry_out(rot_c)
  );

  always_comb begin
    if (op == SHC_ROR) begin
      core_res = rot_res;
      core_c   = rot_c;
    end else begin
      core_res = lin_res;
      core_c   = lin_c;
    end
  end

  assign core_upd = (amount != '0);
  assign core_pay = {core_upd, core_c, core_res};

  shc_out_stage #(.PAY_W(PAY_W), .REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(core_pay),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_pay)
  );

  assign carry_upd = out_pay[PAY_W-1];
  assign carry_out = out_pay[PAY_W-2];
  assign result    = out_pay[DATA_W-1:0];

  generate
    if (REG_OUT) begin : g_chk
      logic accept;
      assign accept = in_valid && in_ready;

      // R2
      zero_amt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && amount == '0 |=>
          result == $past(operand) && carry_out == $past(carry_in) && !carry_upd);
      // R3
      lsl_far_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && opcode == 2'b00 && amount > WIDTH_AMT |=> result == '0 && !carry_out);
      // R5
      asr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && opcode == 2'b10 && amount >= WIDTH_AMT |=>
          result == {DATA_W{$past(operand[DATA_W-1])}} && carry_out == $past(operand[DATA_W-1]));
      // R6
      ror_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && opcode == 2'b11 && amount != '0 && amount[CNT_W-1:0] == '0 |=>
          result == $past(operand) && carry_out == $past(operand[DATA_W-1]));
      // R8
      upd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && amount != '0 |=> carry_upd);
    end
  endgenerate
endmodule

// File: tb/shift_carry_unit_tb_top.sv
module shift_carry_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] operand = '0;
  logic [7:0]  amount = '0;
  logic [1:0]  opcode = '0;
  logic        carry_in = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] result;
  logic        carry_out;
  logic        carry_upd;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  shift_carry_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .operand(operand), .amount(amount), .opcode(opcode), .carry_in(carry_in),
    .out_valid(out_valid), .out_ready(out_ready), .result(result),
    .carry_out(carry_out), .carry_upd(carry_upd)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=timeout exp=finish");
      summary();
    end
  end

  // returns {upd, carry, result}
  function automatic logic [33:0] model(logic [31:0] x, logic [7:0] a, logic [1:0] oc, logic c);
    int n = a;
    int s = n % 32;
    logic [31:0] r = x;
    logic cy = c;
    if (n != 0) begin
      case (oc)
        2'b00: begin
          if (n < 32) begin r = x << n; cy = x[32-n]; end
          else begin r = 0; cy = (n == 32) ? x[0] : 1'b0; end
        end
        2'b01: begin
          if (n < 32) begin r = x >> n; cy = x[n-1]; end
          else begin r = 0; cy = (n == 32) ? x[31] : 1'b0; end
        end
        2'b10: begin
          if (n < 32) begin r = $unsigned($signed(x) >>> n); cy = x[n-1]; end
          else begin r = {32{x[31]}}; cy = x[31]; end
        end
        default: begin
          if (s == 0) begin r = x; cy = x[31]; end
          else begin r = (x >> s) | (x << (32 - s)); cy = x[s-1]; end
        end
      endcase
    end
    return {(n != 0), cy, r};
  endfunction

  function automatic string tag(logic [7:0] a, logic [1:0] oc);
    if (a == 0) return "R2";
    case (oc)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return (a[4:0] == 0) ? "R6" : "R7";
    endcase
  endfunction

  task automatic cmp1(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at negedge, captured at next posedge, sampled at following negedge
  task automatic run_op(logic [31:0] x, logic [7:0] a, logic [1:0] oc, logic c);
    logic [33:0] e;
    @(negedge clk);
    operand = x; amount = a; opcode = oc; carry_in = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    e = model(x, a, oc, c);
    // R1 R8 R9 together with the operation tag
    cmp1(tag(a, oc), {29'd0, out_valid, carry_upd, carry_out, result}, {29'd0, 1'b1, e});
  endtask

  initial begin
    logic [31:0] pats [4];
    logic [33:0] ea, eb;
    pats[0] = 32'h8000_0001;
    pats[1] = 32'h7FFF_FFFE;
    pats[2] = 32'hA5A5_3C3C;
    pats[3] = 32'h0000_0001;
    void'($urandom(32'd1357));

    // R10 reset state
    repeat (3) @(negedge clk);
    cmp1("R10", {62'd0, out_valid, in_ready}, {62'd0, 1'b0, 1'b1});
    rst_n = 1'b1;
    @(negedge clk);
    cmp1("R10", {62'd0, out_valid, in_ready}, {62'd0, 1'b0, 1'b1});

    // directed corners
    run_op(32'h0000_0001, 8'd32, 2'b00, 1'b0);  // R3 carry from bit 0
    run_op(32'h8000_0000, 8'd32, 2'b01, 1'b0);  // R4 carry from bit 31
    run_op(32'h8000_0000, 8'd200, 2'b10, 1'b0); // R5 sign fill
    run_op(32'h8000_0000, 8'd64, 2'b11, 1'b0);  // R6
    run_op(32'h1234_5678, 8'd0, 2'b11, 1'b1);   // R2
    run_op(32'h0000_0001, 8'd1, 2'b11, 1'b0);   // R7

    // full sweep
    for (int oc = 0; oc < 4; oc++)
      for (int p = 0; p < 4; p++)
        for (int a = 0; a < 256; a++)
          run_op(pats[p], 8'(a), 2'(oc), 1'(a ^ p));

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      a = ($urandom % 2) ? 8'($urandom % 41) : 8'($urandom);
      run_op($urandom, a, 2'($urandom), 1'($urandom));
    end

    // R9 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    operand = 32'hF000_000F; amount = 8'd4; opcode = 2'b01; carry_in = 1'b0; in_valid = 1'b1;
    ea = model(32'hF000_000F, 8'd4, 2'b01, 1'b0);
    @(negedge clk);
    operand = 32'h0000_00F0; amount = 8'd4; opcode = 2'b00; carry_in = 1'b1;
    eb = model(32'h0000_00F0, 8'd4, 2'b00, 1'b1);
    for (int k = 0; k < 4; k++) begin
      cmp1("R9", {29'd0, out_valid, carry_upd, carry_out, result}, {29'd0, 1'b1, ea});
      cmp1("R9", {63'd0, in_ready}, 64'd0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    cmp1("R9", {29'd0, out_valid, carry_upd, carry_out, result}, {29'd0, 1'b1, eb});
    @(negedge clk);
    cmp1("R9", {63'd0, out_valid}, 64'd0);

    done = 1;
    summary();
  end
endmodule